// File: doc/BRIEF.md
# Command and Receive FIFO Pair for an I2C Master

This block holds the two queues that sit between a host register interface and an I2C master bus engine. Host writes to the data/command port enter a command queue. Each entry is either a byte to transmit or a read request, chosen by a ninth bit. The bus engine takes commands from the head of that queue. It places each received byte into a receive queue, which the host drains through the same data port.

Both fill levels are visible as outputs. Two flags compare those levels with host-programmed thresholds. One flag asks for more commands. The other announces received data. Three one-cycle error pulses report a write into a full command queue, a byte arriving at a full receive queue, and a host read of an empty receive queue. An abort event empties both queues in one cycle. Taking the controller out of its enabled state does the same.

Top module: `cmdRxFifoPair`

## Requirements
- R1: After reset, txLevel and rxLevel are 0, txEmptyFlag is 1, and rxFullFlag, txOverErr, rxOverErr and rxUnderErr are 0.
- R2: A write with hostWrData[8]=0 queues hostWrData[7:0] as a transmit byte. txLevel counts the entry from the cycle after the write. The engine sees the entries in write order, with engCmdIsRead=0 and engCmdByte equal to the byte.
- R3: A write with hostWrData[8]=1 queues a read request. Its data bits are ignored: the engine sees engCmdIsRead=1 and engCmdByte=0.
- R4: Each engRxValid cycle queues engRxByte. hostRdData always shows the oldest stored byte, and a hostRdReq cycle removes it. Bytes leave in arrival order, and rxLevel tracks the count.
- R5: txEmptyFlag is 1 exactly while txLevel <= txThresh.
- R6: rxFullFlag is 1 exactly while rxLevel > rxThresh. With rxThresh=0 the flag rises as soon as one byte is stored.
- R7: A write while txLevel equals DEPTH (default 8) is dropped and leaves the queue contents unchanged. txOverErr is high for the single cycle after that write.
- R8: A received byte while rxLevel equals DEPTH is dropped and leaves the queue contents unchanged. rxOverErr is high for the single cycle after it.
- R9: hostRdReq while rxLevel is 0 leaves rxLevel at 0. rxUnderErr is high for the single cycle after it.
- R10: A cycle with abortEvt=1 empties both queues by the next cycle. Every write, read, pop, received byte and error in that cycle is discarded.
- R11: While enable=0 both queues are empty and every write and received byte is discarded.
- R12: Fullness is judged on the level at the start of the cycle. A push and a pop on the same non-empty, non-full queue in one cycle leave its level unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enabled; low empties and holds both queues |
| abortEvt | input | 1 | Transfer abort; flushes both queues |
| txThresh | input | PTR_W | Command queue threshold |
| rxThresh | input | PTR_W | Receive queue threshold |
| hostWrValid | input | 1 | Host write to the data/command port |
| hostWrData | input | 9 | Bit 8 = read request, bits 7:0 = byte |
| hostRdReq | input | 1 | Host read of the data port (pops a byte) |
| hostRdData | output | 8 | Oldest received byte |
| engPop | input | 1 | Engine takes the head command |
| engCmdValid | output | 1 | Command queue is not empty |
| engCmdIsRead | output | 1 | Head command is a read request |
| engCmdByte | output | 8 | Head command byte (0 for read requests) |
| engRxValid | input | 1 | Engine delivers a received byte |
| engRxByte | input | 8 | Received byte |
| txLevel | output | PTR_W+1 | Command queue fill level |
| rxLevel | output | PTR_W+1 | Receive queue fill level |
| txEmptyFlag | output | 1 | txLevel at or below txThresh |
| rxFullFlag | output | 1 | rxLevel above rxThresh |
| txOverErr | output | 1 | Command queue overflow pulse |
| rxOverErr | output | 1 | Receive queue overflow pulse |
| rxUnderErr | output | 1 | Receive queue underflow pulse |

## Verification
On each queue, a push and a pop can fall in the same cycle. The bench provokes this by driving a host write together with an engine pop, and a received byte together with a host read, both on a partly filled queue. It judges the result by an unchanged level and by the scoreboard receiving the old head first. An abort can coincide with a write and a received byte. There the bench expects both levels at zero and no error pulse in the next cycle.

// File: rtl/cmdfifo_pkg.sv
package cmdfifo_pkg;
  localparam int CMD_READ_BIT = 8;
  localparam int CMD_W = 9;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } fifoStrobes_t;
endpackage

// File: rtl/fifoLane.sv
module fifoLane #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [LVL_W-1:0] level
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= advance(wrPtr);
      if (pop)  rdPtr <= advance(rdPtr);
      case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/cmdRxDatapath.sv
module cmdRxDatapath
  import cmdfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [CMD_W-1:0]  hostWrData,
  input  logic [BYTE_W-1:0] engRxByte,
  output logic [CMD_W-1:0]  txHead,
  output logic [BYTE_W-1:0] rxHead,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel
);
  logic [CMD_W-1:0] txEntry;

  // A read request keeps only its marker bit; the byte field is zeroed.
  assign txEntry = hostWrData[CMD_READ_BIT]
                 ? {1'b1, {BYTE_W{1'b0}}}
                 : hostWrData;

  fifoLane #(.WIDTH(CMD_W), .DEPTH(DEPTH)) txLane (
    .clk(clk), .rstN(rstN),
    .push(strobes.txPush), .pop(strobes.txPop), .flush(strobes.flush),
    .wrData(txEntry), .rdData(txHead), .level(txLevel)
  );

  fifoLane #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) rxLane (
    .clk(clk), .rstN(rstN),
    .push(strobes.rxPush), .pop(strobes.rxPop), .flush(strobes.flush),
    .wrData(engRxByte), .rdData(rxHead), .level(rxLevel)
  );
endmodule

// File: rtl/cmdRxControl.sv
module cmdRxControl
  import cmdfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             abortEvt,
  input  logic             hostWrValid,
  input  logic             hostRdReq,
  input  logic             engPop,
  input  logic             engRxValid,
  input  logic [PTR_W-1:0] txThresh,
  input  logic [PTR_W-1:0] rxThresh,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  output fifoStrobes_t     strobes,
  output logic             engCmdValid,
  output logic             txEmptyFlag,
  output logic             rxFullFlag,
  output logic             txOverErr,
  output logic             rxOverErr,
  output logic             rxUnderErr
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic flush, txFull, rxFull, txEmpty, rxEmpty;

  assign flush   = abortEvt || !enable;
  assign txFull  = (txLevel == FULL);
  assign rxFull  = (rxLevel == FULL);
  assign txEmpty = (txLevel == '0);
  assign rxEmpty = (rxLevel == '0);

  always_comb begin
    strobes.flush  = flush;
    strobes.txPush = !flush && hostWrValid && !txFull;
    strobes.txPop  = !flush && engPop && !txEmpty;
    strobes.rxPush = !flush && engRxValid && !rxFull;
    strobes.rxPop  = !flush && hostRdReq && !rxEmpty;
  end

  assign engCmdValid = !txEmpty;
  assign txEmptyFlag = (txLevel <= {1'b0, txThresh});
  assign rxFullFlag  = (rxLevel > {1'b0, rxThresh});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverErr  <= 1'b0;
      rxOverErr  <= 1'b0;
      rxUnderErr <= 1'b0;
    end else begin
      txOverErr  <= !flush && hostWrValid && txFull;
      rxOverErr  <= !flush && engRxValid && rxFull;
      rxUnderErr <= !flush && hostRdReq && rxEmpty;
    end
  end
endmodule

// File: rtl/cmdRxFifoPair.sv
module cmdRxFifoPair
  import cmdfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             abortEvt,
  input  logic [PTR_W-1:0] txThresh,
  input  logic [PTR_W-1:0] rxThresh,
  input  logic             hostWrValid,
  input  logic [8:0]       hostWrData,
  input  logic             hostRdReq,
  output logic [7:0]       hostRdData,
  input  logic             engPop,
  output logic             engCmdValid,
  output logic             engCmdIsRead,
  output logic [7:0]       engCmdByte,
  input  logic             engRxValid,
  input  logic [7:0]       engRxByte,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic             txEmptyFlag,
  output logic             rxFullFlag,
  output logic             txOverErr,
  output logic             rxOverErr,
  output logic             rxUnderErr
);
  fifoStrobes_t strobes;
  logic [CMD_W-1:0] txHead;

  cmdRxControl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .abortEvt(abortEvt),
    .hostWrValid(hostWrValid), .hostRdReq(hostRdReq),
    .engPop(engPop), .engRxValid(engRxValid),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .strobes(strobes), .engCmdValid(engCmdValid),
    .txEmptyFlag(txEmptyFlag), .rxFullFlag(rxFullFlag),
    .txOverErr(txOverErr), .rxOverErr(rxOverErr), .rxUnderErr(rxUnderErr)
  );

  cmdRxDatapath #(.DEPTH(DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hostWrData(hostWrData), .engRxByte(engRxByte),
    .txHead(txHead), .rxHead(hostRdData),
    .txLevel(txLevel), .rxLevel(rxLevel)
  );

  assign engCmdIsRead = txHead[CMD_READ_BIT];
  assign engCmdByte   = txHead[BYTE_W-1:0];
endmodule

// File: rtl/cmdRxFifoPairChecker.sv
module cmdRxFifoPairChecker #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = PTR_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             abortEvt,
  input logic             hostWrValid,
  input logic             hostRdReq,
  input logic             engPop,
  input logic             engRxValid,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic             txOverErr,
  input logic             rxOverErr,
  input logic             rxUnderErr
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  logic live;
  assign live = enable && !abortEvt;

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    txLevel <= FULL); // R7
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rxLevel <= FULL); // R8
  AST_TX_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (live && hostWrValid && txLevel == FULL) |=> txOverErr); // R7
  AST_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (live && engRxValid && rxLevel == FULL) |=> rxOverErr); // R8
  AST_RX_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (live && hostRdReq && rxLevel == '0) |=> (rxUnderErr && rxLevel == '0)); // R9
  AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    abortEvt |=> (txLevel == '0 && rxLevel == '0)); // R10
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (abortEvt || !enable) |=> (!txOverErr && !rxOverErr && !rxUnderErr)); // R10
  AST_DISABLE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txLevel == '0 && rxLevel == '0)); // R11
  AST_TX_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (live && hostWrValid && engPop && txLevel != '0 && txLevel != FULL)
      |=> txLevel == $past(txLevel)); // R12
  AST_RX_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (live && engRxValid && hostRdReq && rxLevel != '0 && rxLevel != FULL)
      |=> rxLevel == $past(rxLevel)); // R12
endmodule

bind cmdRxFifoPair cmdRxFifoPairChecker #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rstN(rstN), .enable(enable), .abortEvt(abortEvt),
  .hostWrValid(hostWrValid), .hostRdReq(hostRdReq),
  .engPop(engPop), .engRxValid(engRxValid),
  .txLevel(txLevel), .rxLevel(rxLevel),
  .txOverErr(txOverErr), .rxOverErr(rxOverErr), .rxUnderErr(rxUnderErr)
);

// File: tb/tb_cmdRxFifoPair.sv
`timescale 1ns/1ps
module tb_cmdRxFifoPair;
  localparam int DEPTH = 8;
  localparam int PTR_W = 3;
  localparam int LVL_W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, enable, abortEvt, hostWrValid, hostRdReq, engPop, engRxValid;
  logic [PTR_W-1:0] txThresh, rxThresh;
  logic [8:0] hostWrData;
  logic [7:0] hostRdData, engCmdByte, engRxByte;
  logic engCmdValid, engCmdIsRead, txEmptyFlag, rxFullFlag;
  logic txOverErr, rxOverErr, rxUnderErr;
  logic [LVL_W-1:0] txLevel, rxLevel;

  cmdRxFifoPair #(.DEPTH(DEPTH)) dut (.*);

  int checks = 0;
  int bad = 0;
  logic [8:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [8:0] expCmd;
  logic [7:0] expByte;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares each head as it is consumed against the scoreboard.
  always @(negedge clk) begin
    if (rstN && enable && !abortEvt) begin
      if (engPop && engCmdValid) begin
        if (txQ.size() == 0) chk("R2", "unexpected command", 1, 0);
        else begin
          expCmd = txQ.pop_front();
          chk("R2/R3", "command head", {23'd0, engCmdIsRead, engCmdByte}, {23'd0, expCmd});
        end
      end
      if (hostRdReq && rxLevel != 0) begin
        if (rxQ.size() == 0) chk("R4", "unexpected rx byte", 1, 0);
        else begin
          expByte = rxQ.pop_front();
          chk("R4", "rx head", {24'd0, hostRdData}, {24'd0, expByte});
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic hostWrite(logic [8:0] d, bit keep);
    hostWrValid = 1'b1;
    hostWrData = d;
    if (keep) txQ.push_back(d[8] ? 9'h100 : d);
    cyc();
    hostWrValid = 1'b0;
  endtask

  task automatic engRx(logic [7:0] b, bit keep);
    engRxValid = 1'b1;
    engRxByte = b;
    if (keep) rxQ.push_back(b);
    cyc();
    engRxValid = 1'b0;
  endtask

  task automatic popCmds(int n);
    engPop = 1'b1;
    repeat (n) cyc();
    engPop = 1'b0;
  endtask

  task automatic readBytes(int n);
    hostRdReq = 1'b1;
    repeat (n) cyc();
    hostRdReq = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b1; abortEvt = 1'b0;
    hostWrValid = 1'b0; hostRdReq = 1'b0; engPop = 1'b0; engRxValid = 1'b0;
    hostWrData = '0; engRxByte = '0; txThresh = 3'd2; rxThresh = 3'd0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk("R1", "txLevel", txLevel, 0);
    chk("R1", "rxLevel", rxLevel, 0);
    chk("R1", "txEmptyFlag", txEmptyFlag, 1);
    chk("R1", "rxFullFlag", rxFullFlag, 0);
    chk("R1", "errors", {txOverErr, rxOverErr, rxUnderErr}, 0);

    // R2 / R3 / R5: bytes and a read request
    cyc();
    hostWrite(9'h0A5, 1);
    hostWrite(9'h03C, 1);
    hostWrite(9'h1FF, 1);
    @(negedge clk);
    chk("R2", "txLevel after 3 writes", txLevel, 3);
    chk("R5", "txEmptyFlag level 3 thresh 2", txEmptyFlag, 0);
    popCmds(2);
    @(negedge clk);
    chk("R5", "txEmptyFlag level 1 thresh 2", txEmptyFlag, 1);
    chk("R3", "head is read request", engCmdIsRead, 1);
    chk("R3", "read request byte zero", engCmdByte, 0);
    popCmds(1);
    @(negedge clk);
    chk("R2", "txLevel drained", txLevel, 0);

    // R12: write and pop in one cycle
    hostWrite(9'h011, 1);
    hostWrValid = 1'b1; hostWrData = 9'h022; engPop = 1'b1;
    txQ.push_back(9'h022);
    cyc();
    hostWrValid = 1'b0; engPop = 1'b0;
    @(negedge clk);
    chk("R12", "txLevel with push+pop", txLevel, 1);
    popCmds(1);

    // R7: overflow of the command queue
    for (int i = 0; i < DEPTH; i++) hostWrite(9'(8'h40 + i), 1);
    @(negedge clk);
    chk("R7", "txLevel full", txLevel, DEPTH);
    chk("R7", "no early overflow", txOverErr, 0);
    hostWrite(9'h077, 0);
    @(negedge clk);
    chk("R7", "txOverErr pulse", txOverErr, 1);
    chk("R7", "txLevel held", txLevel, DEPTH);
    cyc();
    @(negedge clk);
    chk("R7", "txOverErr single cycle", txOverErr, 0);
    popCmds(DEPTH);
    @(negedge clk);
    chk("R7", "txLevel after drain", txLevel, 0);

    // R6 / R4: receive flag thresholds
    engRx(8'h5A, 1);
    @(negedge clk);
    chk("R6", "rxFullFlag thresh 0 one byte", rxFullFlag, 1);
    rxThresh = 3'd2;
    #1;
    chk("R6", "rxFullFlag level 1 thresh 2", rxFullFlag, 0);
    engRx(8'hC3, 1);
    @(negedge clk);
    chk("R6", "rxFullFlag level 2 thresh 2", rxFullFlag, 0);
    engRx(8'h81, 1);
    @(negedge clk);
    chk("R6", "rxFullFlag level 3 thresh 2", rxFullFlag, 1);
    chk("R4", "rxLevel 3", rxLevel, 3);
    readBytes(3);
    @(negedge clk);
    chk("R4", "rxLevel drained", rxLevel, 0);

    // R8: overflow of the receive queue
    for (int i = 0; i < DEPTH; i++) engRx(8'(8'hA0 + i), 1);
    engRx(8'hEE, 0);
    @(negedge clk);
    chk("R8", "rxOverErr pulse", rxOverErr, 1);
    chk("R8", "rxLevel held", rxLevel, DEPTH);
    readBytes(DEPTH);

    // R9: underflow
    readBytes(1);
    @(negedge clk);
    chk("R9", "rxUnderErr pulse", rxUnderErr, 1);
    chk("R9", "rxLevel stays 0", rxLevel, 0);

    // R12: receive push and host read together
    engRx(8'h12, 1);
    engRxValid = 1'b1; engRxByte = 8'h34; hostRdReq = 1'b1;
    rxQ.push_back(8'h34);
    cyc();
    engRxValid = 1'b0; hostRdReq = 1'b0;
    @(negedge clk);
    chk("R12", "rxLevel with push+pop", rxLevel, 1);
    readBytes(1);

    // R10: abort with a write and a received byte in the same cycle
    hostWrite(9'h001, 0);
    hostWrite(9'h002, 0);
    engRx(8'h01, 0);
    abortEvt = 1'b1; hostWrValid = 1'b1; hostWrData = 9'h099;
    engRxValid = 1'b1; engRxByte = 8'h55;
    cyc();
    abortEvt = 1'b0; hostWrValid = 1'b0; engRxValid = 1'b0;
    @(negedge clk);
    chk("R10", "txLevel after abort", txLevel, 0);
    chk("R10", "rxLevel after abort", rxLevel, 0);
    chk("R10", "no error after abort", {txOverErr, rxOverErr, rxUnderErr}, 0);

    // R11: disable empties and ignores writes
    hostWrite(9'h003, 0);
    engRx(8'h04, 0);
    enable = 1'b0;
    cyc();
    @(negedge clk);
    chk("R11", "txLevel disabled", txLevel, 0);
    chk("R11", "rxLevel disabled", rxLevel, 0);
    hostWrite(9'h005, 0);
    engRx(8'h06, 0);
    @(negedge clk);
    chk("R11", "write ignored while disabled", txLevel, 0);
    chk("R11", "rx ignored while disabled", rxLevel, 0);
    enable = 1'b1;
    hostWrite(9'h0E7, 1);
    popCmds(1);
    @(negedge clk);
    chk("R2", "scoreboard tx empty", txQ.size(), 0);
    chk("R4", "scoreboard rx empty", rxQ.size(), 0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule